// File: doc/BRIEF.md
# 28-to-4 Lane Parallel Serializer

This block takes a 28-bit parallel word once per pixel-clock period and sends it out over four serial data lanes, seven bits per lane per period. A fifth lane carries a copy of the pixel clock, built as a seven-slot pattern at the same bit rate as the data. The word is sampled on either the rising or the falling edge of the pixel clock, chosen at run time by a select input.

Shift timing comes from a bit clock input that runs at seven times the pixel rate and is phase-aligned with it, so that a bit-clock rising edge coincides with every pixel-clock rising edge. The sampled word crosses into the bit-clock domain through a holding register that loads at one fixed slot of each period. It is then scattered across the lanes in a fixed, non-sequential bit order. An active-low shutdown input clears every register and forces all five lanes low.

Top module: `ser28_tx`

## Requirements
- R1: With edge_sel_i high, the word on data_i at the clk_px_i rising edge that opens a pixel period is the one transmitted. A value present only between that rising edge and the next falling edge is not sent.
- R2: With edge_sel_i low, the word on data_i at the clk_px_i falling edge is the one transmitted. edge_sel_i may change between periods while running, and the new selection applies to the next word handed over.
- R3: lane_o[0] sends data bits 7, 6, 4, 3, 2, 1, 0, in that time order.
- R4: lane_o[1] sends data bits 18, 15, 14, 13, 12, 9, 8, in that time order.
- R5: lane_o[2] sends data bits 26, 25, 24, 22, 21, 20, 19, in that time order.
- R6: lane_o[3] sends data bits 23, 17, 16, 11, 10, 5, 27, in that time order.
- R7: Each pixel period has seven bit-clock slots, and slot 0 begins at the clk_px_i rising edge. A word sampled by the rising edge that opens period p, or by the falling edge inside period p, goes out in period p+1. Its first listed bit is sent in slot 0.
- R8: Once framing has started, clk_lane_o shows 1,1,0,0,0,1,1 over slots 0 to 6 of every pixel period.
- R9: While rst_ni is low, lane_o and clk_lane_o are 0 at once, without waiting for a clock edge, and every register is cleared.
- R10: The bit period in which rst_ni rises counts as slot 0. During that whole pixel period, all five lanes stay 0. No word sampled before the release is ever sent. With rising-edge sampling, the following period carries an all-zero word together with the clock pattern.
- R11: The holding register loads only at the end of slot HOLD_SLOT (default 3). Changes on data_i after the sampling edge do not alter the slice that is already queued or being sent.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_bit_i | input | 1 | Bit clock, seven times the pixel rate, rising edge aligned to clk_px_i rising edge |
| clk_px_i | input | 1 | Pixel clock |
| rst_ni | input | 1 | Active-low asynchronous shutdown and clear |
| edge_sel_i | input | 1 | 1: sample on rising pixel edge, 0: on falling edge |
| data_i | input | 28 | Parallel input word |
| lane_o | output | 4 | Serial data lanes, first listed bit first |
| clk_lane_o | output | 1 | Forwarded pixel clock lane |

## Verification
The bench builds the block with its default parameters: a hold slot of 3 and the 1100011 clock pattern. With these values the holding register loads one slot-half after the falling sampling edge, so a single bench can show both selections. In every period the bench drives one value before the falling edge and a different value after it. Because of that, each frame reveals which edge was used, and it also shows that the later change does not tear the slice being sent. Two shutdowns are placed at different points: one before any traffic and one in the middle of a period with traffic in flight. Together they cover the zero-output rule, realignment of slot 0 to the release, and the different first-frame behaviour under the two edge selections.

// File: rtl/ser28_pkg.sv
package ser28_pkg;
  localparam int unsigned NUM_LANES = 4;
  localparam int unsigned SLOTS     = 7;
  localparam int unsigned WORD_W    = NUM_LANES * SLOTS;
  localparam int unsigned SLOT_W    = $clog2(SLOTS);

  typedef logic [WORD_W-1:0] word_t;
  typedef logic [SLOTS-1:0]  slice_t;

  // Source bit per lane, in transmit order (first entry leaves first).
  localparam int unsigned LANE_SRC [NUM_LANES][SLOTS] = '{
    '{ 7,  6,  4,  3,  2,  1,  0},
    '{18, 15, 14, 13, 12,  9,  8},
    '{26, 25, 24, 22, 21, 20, 19},
    '{23, 17, 16, 11, 10,  5, 27}
  };

  function automatic slice_t pick_slice(word_t w, int unsigned lane);
    slice_t s;
    for (int unsigned p = 0; p < SLOTS; p++) s[SLOTS-1-p] = w[LANE_SRC[lane][p]];
    return s;
  endfunction
endpackage

// File: rtl/ser28_capture.sv
module ser28_capture #(
  parameter int unsigned W = 28
) (
  input  logic         clk_px_i,
  input  logic         rst_ni,
  input  logic [W-1:0] data_i,
  output logic [W-1:0] rise_q_o,
  output logic [W-1:0] fall_q_o
);
  always_ff @(posedge clk_px_i or negedge rst_ni) begin
    if (!rst_ni) rise_q_o <= '0;
    else         rise_q_o <= data_i;
  end

  always_ff @(negedge clk_px_i or negedge rst_ni) begin
    if (!rst_ni) fall_q_o <= '0;
    else         fall_q_o <= data_i;
  end
endmodule

// File: rtl/ser28_slot_ctr.sv
module ser28_slot_ctr #(
  parameter  int unsigned SLOTS     = 7,
  parameter  int unsigned HOLD_SLOT = 3,
  localparam int unsigned SW        = $clog2(SLOTS)
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  output logic [SW-1:0] slot_o,
  output logic          hold_ld_o,
  output logic          xfer_o
);
  localparam logic [SW-1:0] LAST = SW'(SLOTS - 1);
  localparam logic [SW-1:0] HOLD = SW'(HOLD_SLOT);

  logic [SW-1:0] slot_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)            slot_q <= '0;
    else if (slot_q == LAST) slot_q <= '0;
    else                    slot_q <= slot_q + 1'b1;
  end

  assign slot_o    = slot_q;
  assign hold_ld_o = (slot_q == HOLD);
  assign xfer_o    = (slot_q == LAST);
endmodule

// File: rtl/ser28_lane.sv
module ser28_lane #(
  parameter int unsigned W = 7
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         load_i,
  input  logic [W-1:0] slice_i,
  output logic         bit_o
);
  logic [W-1:0] sr_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     sr_q <= '0;
    else if (load_i) sr_q <= slice_i;
    else             sr_q <= {sr_q[W-2:0], 1'b0};
  end

  assign bit_o = sr_q[W-1];
endmodule

// File: rtl/ser28_tx.sv
module ser28_tx import ser28_pkg::*; #(
  parameter int unsigned      HOLD_SLOT   = 3,
  parameter logic [SLOTS-1:0] CLK_PATTERN = 7'b1100011
) (
  input  logic                 clk_bit_i,
  input  logic                 clk_px_i,
  input  logic                 rst_ni,
  input  logic                 edge_sel_i,
  input  logic [WORD_W-1:0]    data_i,
  output logic [NUM_LANES-1:0] lane_o,
  output logic                 clk_lane_o
);
  localparam int unsigned N_SER = NUM_LANES + 1;

  word_t             rise_q, fall_q, hold_q;
  logic [SLOT_W-1:0] slot_q;
  logic              hold_ld, xfer;
  slice_t            slice [N_SER];
  logic [N_SER-1:0]  ser_bits;

  ser28_capture #(.W(WORD_W)) u_cap (
    .clk_px_i (clk_px_i),
    .rst_ni   (rst_ni),
    .data_i   (data_i),
    .rise_q_o (rise_q),
    .fall_q_o (fall_q)
  );

  ser28_slot_ctr #(.SLOTS(SLOTS), .HOLD_SLOT(HOLD_SLOT)) u_ctr (
    .clk_i     (clk_bit_i),
    .rst_ni    (rst_ni),
    .slot_o    (slot_q),
    .hold_ld_o (hold_ld),
    .xfer_o    (xfer)
  );

  // Crossing point: loads mid-period, clear of both sampling edges.
  always_ff @(posedge clk_bit_i or negedge rst_ni) begin
    if (!rst_ni)      hold_q <= '0;
    else if (hold_ld) hold_q <= edge_sel_i ? rise_q : fall_q;
  end

  always_comb begin
    for (int unsigned l = 0; l < NUM_LANES; l++) slice[l] = pick_slice(hold_q, l);
    slice[NUM_LANES] = CLK_PATTERN;
  end

  for (genvar g = 0; g < N_SER; g++) begin : g_ser
    ser28_lane #(.W(SLOTS)) u_lane (
      .clk_i   (clk_bit_i),
      .rst_ni  (rst_ni),
      .load_i  (xfer),
      .slice_i (slice[g]),
      .bit_o   (ser_bits[g])
    );
  end

  assign lane_o     = ser_bits[NUM_LANES-1:0];
  assign clk_lane_o = ser_bits[NUM_LANES];
endmodule

// File: rtl/ser28_tx_chk.sv
module ser28_tx_chk import ser28_pkg::*; #(
  parameter int unsigned      HOLD_SLOT   = 3,
  parameter logic [SLOTS-1:0] CLK_PATTERN = 7'b1100011
) (
  input logic                 clk_bit_i,
  input logic                 rst_ni,
  input logic [SLOT_W-1:0]    slot_i,
  input logic [WORD_W-1:0]    hold_i,
  input logic                 xfer_i,
  input logic [NUM_LANES-1:0] lane_i,
  input logic                 clk_lane_i
);
  logic framing_q;

  always_ff @(posedge clk_bit_i or negedge rst_ni) begin
    if (!rst_ni)     framing_q <= 1'b0;
    else if (xfer_i) framing_q <= 1'b1;
  end

  AST_SHDN_QUIET: assert property (@(posedge clk_bit_i)
    !rst_ni |-> (lane_i == '0 && !clk_lane_i)) else $error("shutdown output"); // R9

  AST_PRE_FRAME_QUIET: assert property (@(posedge clk_bit_i) disable iff (!rst_ni)
    !framing_q |-> (lane_i == '0 && !clk_lane_i)) else $error("early output"); // R10

  AST_CLK_LANE_PATTERN: assert property (@(posedge clk_bit_i) disable iff (!rst_ni)
    framing_q |-> (clk_lane_i == CLK_PATTERN[SLOTS-1-slot_i])) else $error("clock lane"); // R8

  AST_HOLD_STABLE: assert property (@(posedge clk_bit_i) disable iff (!rst_ni)
    (slot_i != SLOT_W'(HOLD_SLOT)) |=> $stable(hold_i)) else $error("hold torn"); // R11

  AST_LANE0_HEAD: assert property (@(posedge clk_bit_i) disable iff (!rst_ni)
    xfer_i |=> (lane_i[0] == $past(hold_i[7]))) else $error("lane0 head"); // R3
endmodule

bind ser28_tx ser28_tx_chk #(.HOLD_SLOT(HOLD_SLOT), .CLK_PATTERN(CLK_PATTERN)) u_chk (
  .clk_bit_i  (clk_bit_i),
  .rst_ni     (rst_ni),
  .slot_i     (slot_q),
  .hold_i     (hold_q),
  .xfer_i     (xfer),
  .lane_i     (lane_o),
  .clk_lane_i (clk_lane_o)
);

// File: tb/ser28_tx_tb_top.sv
`timescale 1ns/1ps
module ser28_tx_tb_top;
  localparam logic [6:0] CLK_PAT = 7'b1100011;

  logic        clk_bit = 1'b0;
  logic        clk_px  = 1'b0;
  logic        rst_n   = 1'b1;
  logic        edge_sel = 1'b1;
  logic [27:0] data = '0;
  logic [3:0]  lane;
  logic        clk_lane;

  int errors = 0;
  int checks = 0;
  int per = -1;
  bit done = 0;

  typedef struct {
    int          p;
    logic [27:0] w;
    bit          clk_on;
    string       tag;
  } exp_t;
  exp_t q[$];

  int src [4][7] = '{
    '{ 7,  6,  4,  3,  2,  1,  0},
    '{18, 15, 14, 13, 12,  9,  8},
    '{26, 25, 24, 22, 21, 20, 19},
    '{23, 17, 16, 11, 10,  5, 27}
  };
  string lane_req [4] = '{"R3", "R4", "R5", "R6"};

  ser28_tx dut_i (
    .clk_bit_i  (clk_bit),
    .clk_px_i   (clk_px),
    .rst_ni     (rst_n),
    .edge_sel_i (edge_sel),
    .data_i     (data),
    .lane_o     (lane),
    .clk_lane_o (clk_lane)
  );

  always #2.5 clk_bit = ~clk_bit;
  initial begin
    #2.5 clk_px = 1'b1;
    forever begin
      #17.5 clk_px = 1'b0;
      #17.5 clk_px = 1'b1;
    end
  end
  always @(posedge clk_px) per <= per + 1;

  task automatic chk(input bit ok, input string req, input string what,
                     input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s: actual=%h expected=%h", req, what, act, exp);
    end
  endtask

  function automatic logic [6:0] exp_slice(logic [27:0] w, int l);
    logic [6:0] s;
    for (int k = 0; k < 7; k++) s[6-k] = w[src[l][k]];
    return s;
  endfunction

  task automatic push(input int p, input logic [27:0] w, input bit c, input string tag);
    exp_t e;
    e.p = p; e.w = w; e.clk_on = c; e.tag = tag;
    q.push_back(e);
  endtask

  // Driver: called 1 ns after a pixel rising edge.
  task automatic drive(input logic [27:0] early, input logic [27:0] late,
                       input bit do_push, input string tag);
    int p = per;
    #9  data = early;
    #15 data = late;
    if (do_push) begin
      if (edge_sel) push(p + 2, late, 1'b1, tag);
      else          push(p + 1, early, 1'b1, tag);
    end
    @(posedge clk_px); #1;
  endtask

  function automatic logic [27:0] patt(int i);
    case (i)
      0: return 28'h0000001;
      1: return 28'h8000000;
      2: return 28'hAAAAAAA;
      3: return 28'h5555555;
      4: return 28'h00000FF;
      5: return 28'h0000020;
      6: return 28'hFFFF000;
      default: return 28'($urandom);
    endcase
  endfunction

  // Monitor: collects one frame per pixel period and compares it.
  initial begin
    logic [6:0] got [5];
    bit         live;
    int         p;
    exp_t       e;
    forever begin
      @(posedge clk_px); #1;
      p = per;
      live = 1'b1;
      #1.5;
      for (int s = 0; s < 7; s++) begin
        if (s > 0) #5;
        live &= rst_n;
        for (int l = 0; l < 4; l++) got[l][6-s] = lane[l];
        got[4][6-s] = clk_lane;
      end
      while (q.size() > 0 && q[0].p < p) begin
        e = q.pop_front();
        chk(1'b0, "R7", "frame not seen", 32'(p), 32'(e.p));
      end
      if (q.size() > 0 && q[0].p == p) begin
        e = q.pop_front();
        if (live) begin
          for (int l = 0; l < 4; l++)
            chk(got[l] == exp_slice(e.w, l), {e.tag, "/", lane_req[l]},
                $sformatf("lane %0d period %0d", l, p), 32'(got[l]), 32'(exp_slice(e.w, l)));
          chk(got[4] == (e.clk_on ? CLK_PAT : 7'h0), {e.tag, "/R8"},
              $sformatf("clock lane period %0d", p), 32'(got[4]), 32'(e.clk_on ? CLK_PAT : 7'h0));
        end
      end
    end
  end

  initial begin
    data = 28'hFFFFFFF;
    #1 rst_n = 1'b0;
    #20;
    chk(lane == 4'h0 && !clk_lane, "R9", "reset outputs", {27'h0, clk_lane, lane}, 32'h0);
    // Initial release: rising sampling, junk on bus before release must never appear.
    @(posedge clk_px); @(posedge clk_px); #1;
    chk(lane == 4'h0 && !clk_lane, "R9", "reset outputs late", {27'h0, clk_lane, lane}, 32'h0);
    rst_n = 1'b1;
    push(per, 28'h0, 1'b0, "R10");
    push(per + 1, 28'h0, 1'b1, "R10");
    for (int i = 0; i < 10; i++) begin
      logic [27:0] v = patt(i);
      drive(~v, v, 1'b1, "R1/R7");
    end
    drive(28'h1234567, 28'h1234567, 1'b0, "");
    drive(28'h7654321, 28'h7654321, 1'b0, "");
    // Run-time switch to falling-edge sampling.
    edge_sel = 1'b0;
    for (int i = 0; i < 10; i++) begin
      logic [27:0] v = patt(i);
      drive(v, ~v, 1'b1, "R2/R11");
    end
    // Mid-period shutdown with traffic in flight.
    #11 rst_n = 1'b0;
    q.delete();
    #1;
    chk(lane == 4'h0 && !clk_lane, "R9", "outputs at shutdown", {27'h0, clk_lane, lane}, 32'h0);
    data = 28'hABCDEF1;
    repeat (2) @(posedge clk_px);
    #20;
    chk(lane == 4'h0 && !clk_lane, "R9", "outputs held off", {27'h0, clk_lane, lane}, 32'h0);
    @(posedge clk_px); #1;
    rst_n = 1'b1;
    push(per, 28'h0, 1'b0, "R10");
    drive(28'h0F0F0F0, 28'h3333333, 1'b1, "R10");
    for (int i = 0; i < 4; i++) begin
      logic [27:0] v = patt(7 + i);
      drive(v, ~v, 1'b1, "R2");
    end
    drive(28'h1111111, 28'h1111111, 1'b0, "");
    drive(28'h2222222, 28'h2222222, 1'b0, "");
    edge_sel = 1'b1;
    for (int i = 0; i < 4; i++) begin
      logic [27:0] v = patt(2 + i);
      drive(~v, v, 1'b1, "R1");
    end
    wait (q.size() == 0);
    @(posedge clk_px); #1;
    if (!done) begin
      done = 1;
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    #200000;
    if (!done) begin
      done = 1;
      checks++;
      errors++;
      $display("FAIL R7 watchdog: actual=running expected=finished");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end
endmodule